// File: doc/BRIEF.md
# Dual-Port Shared-Memory Mailbox

This block is a shared word buffer that sits between two processors. Each processor has its own synchronous read/write port. Both ports can reach every data word, so a block written through one port can be read through the other with no copying. Data moves in both directions through the same buffer.

Each direction also has a block-ready indicator. The producing side first writes a whole data block. It then writes the indicator word to announce that the block is ready. The consuming side sees the announcement in one of two ways. It can poll the indicator word, or it can respond to a level interrupt that stays high while unread data is pending.

A mode input selects how the indicator behaves. In counter mode each announcement advances a block count, and the consumer acknowledges by writing back the count it has processed. In semaphore mode each announcement sets a flag. The consumer clears the flag once the block is drained, and a second announcement against a set flag is recorded as an overrun.

Top module: `shared_mailbox`

## Requirements
- R1: Each port reads any data address (0x00 to 0xFD) with one cycle of latency. A word written through one port is returned by a later read through the other port.
- R2: When a port reads an address that is written in the same cycle, by either port, it returns the value the address held before that write.
- R3: When both ports write the same data address in one cycle, port A's data is stored and port B's data is lost. Writes by the two ports to different addresses in the same cycle both take effect.
- R4: Address 0xFE is the A-to-B indicator and 0xFF is the B-to-A indicator. A write by the producer (port A for 0xFE, port B for 0xFF) is an announcement, whatever the data. A read of either address through either port returns that indicator's status word, one cycle later. The status word holds the count in bits 7:0, the acknowledged count in bits 15:8, the flag in bit 16 and the overrun bit in bit 17. All other bits read as zero.
- R5: In counter mode (countMode=1), each announcement adds one to the count, and the count wraps from 255 to 0. A consumer write loads the acknowledged count from write data bits 7:0. The consumer's interrupt is high while the count differs from the acknowledged count.
- R6: In semaphore mode (countMode=0), an announcement sets the flag. A consumer write clears the flag when data bit 0 is 1, and has no effect on the flag when bit 0 is 0. The consumer's interrupt equals the flag.
- R7: In semaphore mode, an announcement made while the flag is set leaves the flag set and sets the overrun bit. The overrun bit stays set until a consumer write with data bit 1 equal to 1.
- R8: In semaphore mode, if the consumer clears the flag in the same cycle as an announcement, the flag ends up set and no overrun is recorded.
- R9: bIrq reports the A-to-B indicator and aIrq reports the B-to-A indicator. Activity on one direction does not change the other direction's indicator or interrupt.
- R10: A synchronous reset clears the counts, the acknowledged counts, the flags, the overrun bits, both interrupts and both read-data outputs.
- R11: An interrupt rises on the clock edge that registers the announcement, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| countMode | input | 1 | 1 selects counter indicators, 0 selects semaphore indicators |
| aAddr | input | 8 | Port A word address |
| aWrData | input | 32 | Port A write data |
| aWrEn | input | 1 | Port A write enable |
| aRdData | output | 32 | Port A read data, one cycle after the address |
| bAddr | input | 8 | Port B word address |
| bWrData | input | 32 | Port B write data |
| bWrEn | input | 1 | Port B write enable |
| bRdData | output | 32 | Port B read data, one cycle after the address |
| aIrq | output | 1 | Level interrupt to port A: B-to-A block pending |
| bIrq | output | 1 | Level interrupt to port B: A-to-B block pending |

## Verification
The interrupt and overrun properties assume that countMode is held steady between resets. A mode change outside reset would leave stale state in the indicator registers. For that reason the stimulus changes the mode only while reset is asserted, and runs the counter and semaphore phases each from a fresh reset. The memory sweeps write every data address through one port and read it back through the other, with values computed from the address. The counter phase steps through more than one full wrap of the eight-bit count, so the wrap and the interrupt dropping at an accidental match are both covered.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Number of transfer directions (A-to-B, B-to-A)
  localparam int IND_PAIRS = 2;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic memWeA;   // port A writes a data word
    logic memWeB;   // port B writes a data word (already collision-gated)
    logic statRdA;  // port A reads an indicator status word
    logic statRdB;  // port B reads an indicator status word
  } dpStrobes_t;

endpackage

// File: rtl/mbox_indicator.sv
module mbox_indicator #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              countMode,
  input  logic              announce,
  input  logic              consWr,
  input  logic [CNT_W-1:0]  consData,
  output logic [DATA_W-1:0] statusWord,
  output logic              irq
);

  localparam int STAT_BITS = 2 * CNT_W + 2;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] ackCount;
  logic             flag;
  logic             overrun;

  logic clrFlag;
  logic clrOvr;
  logic flagSeen;

  assign clrFlag  = consWr & consData[0];
  assign clrOvr   = consWr & consData[1];
  // the producer's set sees any same-cycle clear first
  assign flagSeen = flag & ~clrFlag;

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      ackCount <= '0;
      flag     <= 1'b0;
      overrun  <= 1'b0;
    end else if (countMode) begin
      if (announce) count    <= count + 1'b1;
      if (consWr)   ackCount <= consData;
    end else begin
      flag    <= announce | flagSeen;
      overrun <= (announce & flagSeen) | (overrun & ~clrOvr);
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[STAT_BITS-1:0] = {overrun, flag, ackCount, count};
  end

  assign irq = countMode ? (count != ackCount) : flag;

  a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
    (countMode && announce) |=> (count == CNT_W'($past(count) + 1'b1)));

  a_r6_irq_after_set: assert property (@(posedge clk) disable iff (rst)
    (!countMode && announce) |=> irq);

  a_r7_overrun_flag: assert property (@(posedge clk) disable iff (rst)
    (!countMode && announce && flag && !clrFlag) |=> (overrun && flag));

  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (overrun && !clrOvr) |=> overrun);

  a_r8_clear_and_set: assert property (@(posedge clk) disable iff (rst)
    (!countMode && announce && clrFlag) |=> (flag && (overrun == $past(overrun && !clrOvr))));

endmodule

// File: rtl/mbox_control.sv
module mbox_control
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              countMode,
  input  logic [ADDR_W-1:0]                 aAddr,
  input  logic [DATA_W-1:0]                 aWrData,
  input  logic                              aWrEn,
  input  logic [ADDR_W-1:0]                 bAddr,
  input  logic [DATA_W-1:0]                 bWrData,
  input  logic                              bWrEn,
  output dpStrobes_t                        strobes,
  output logic [IND_PAIRS-1:0][DATA_W-1:0]  statusWords,
  output logic                              aIrq,
  output logic                              bIrq
);

  // the top two addresses hold the indicators; bit 0 picks the direction
  logic aRsv, bRsv;
  assign aRsv = &aAddr[ADDR_W-1:1];
  assign bRsv = &bAddr[ADDR_W-1:1];

  logic [IND_PAIRS-1:0]            annc;
  logic [IND_PAIRS-1:0]            cons;
  logic [IND_PAIRS-1:0][CNT_W-1:0] consData;
  logic [IND_PAIRS-1:0]            irqs;

  // direction 0: A produces, B consumes; direction 1: B produces, A consumes
  assign annc[0]     = aWrEn & aRsv & ~aAddr[0];
  assign cons[0]     = bWrEn & bRsv & ~bAddr[0];
  assign consData[0] = bWrData[CNT_W-1:0];
  assign annc[1]     = bWrEn & bRsv & bAddr[0];
  assign cons[1]     = aWrEn & aRsv & aAddr[0];
  assign consData[1] = aWrData[CNT_W-1:0];

  always_comb begin
    strobes.memWeA  = aWrEn & ~aRsv;
    strobes.memWeB  = bWrEn & ~bRsv & ~(aWrEn & ~aRsv & (aAddr == bAddr));
    strobes.statRdA = aRsv;
    strobes.statRdB = bRsv;
  end

  for (genvar d = 0; d < IND_PAIRS; d++) begin : g_dir
    mbox_indicator #(
      .DATA_W(DATA_W),
      .CNT_W (CNT_W)
    ) u_ind (
      .clk       (clk),
      .rst       (rst),
      .countMode (countMode),
      .announce  (annc[d]),
      .consWr    (cons[d]),
      .consData  (consData[d]),
      .statusWord(statusWords[d]),
      .irq       (irqs[d])
    );
  end

  assign bIrq = irqs[0];
  assign aIrq = irqs[1];

  a_r4_port_a_one_role: assert property (@(posedge clk) disable iff (rst)
    $onehot0({annc[0], cons[1], strobes.memWeA}));

  a_r4_port_b_one_role: assert property (@(posedge clk) disable iff (rst)
    $onehot0({annc[1], cons[0], strobes.memWeB}));

endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  dpStrobes_t                        strobes,
  input  logic [ADDR_W-1:0]                 aAddr,
  input  logic [DATA_W-1:0]                 aWrData,
  input  logic [ADDR_W-1:0]                 bAddr,
  input  logic [DATA_W-1:0]                 bWrData,
  input  logic [IND_PAIRS-1:0][DATA_W-1:0]  statusWords,
  output logic [DATA_W-1:0]                 aRdData,
  output logic [DATA_W-1:0]                 bRdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // both write ports in one process; B is gated off by control on a clash
  always_ff @(posedge clk) begin
    if (strobes.memWeB) mem[bAddr] <= bWrData;
    if (strobes.memWeA) mem[aAddr] <= aWrData;
  end

  // registered reads sample the array before this edge's writes land
  always_ff @(posedge clk) begin
    if (rst) begin
      aRdData <= '0;
      bRdData <= '0;
    end else begin
      aRdData <= strobes.statRdA ? statusWords[aAddr[0]] : mem[aAddr];
      bRdData <= strobes.statRdB ? statusWords[bAddr[0]] : mem[bAddr];
    end
  end

  a_r3_single_writer: assert property (@(posedge clk) disable iff (rst)
    !(strobes.memWeA && strobes.memWeB && (aAddr == bAddr)));

  a_r10_rd_cleared: assert property (@(posedge clk)
    rst |=> ((aRdData == '0) && (bRdData == '0)));

endmodule

// File: rtl/shared_mailbox.sv
module shared_mailbox
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              countMode,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWrData,
  input  logic              aWrEn,
  output logic [DATA_W-1:0] aRdData,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWrData,
  input  logic              bWrEn,
  output logic [DATA_W-1:0] bRdData,
  output logic              aIrq,
  output logic              bIrq
);

  dpStrobes_t                       strobes;
  logic [IND_PAIRS-1:0][DATA_W-1:0] statusWords;

  mbox_control #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .countMode  (countMode),
    .aAddr      (aAddr),
    .aWrData    (aWrData),
    .aWrEn      (aWrEn),
    .bAddr      (bAddr),
    .bWrData    (bWrData),
    .bWrEn      (bWrEn),
    .strobes    (strobes),
    .statusWords(statusWords),
    .aIrq       (aIrq),
    .bIrq       (bIrq)
  );

  mbox_datapath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .aAddr      (aAddr),
    .aWrData    (aWrData),
    .bAddr      (bAddr),
    .bWrData    (bWrData),
    .statusWords(statusWords),
    .aRdData    (aRdData),
    .bRdData    (bRdData)
  );

endmodule

// File: tb/shared_mailbox_bench.sv
`timescale 1ns/1ps
module shared_mailbox_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        countMode = 1'b0;
  logic [7:0]  aAddr = '0, bAddr = '0;
  logic [31:0] aWrData = '0, bWrData = '0;
  logic        aWrEn = 1'b0, bWrEn = 1'b0;
  logic [31:0] aRdData, bRdData;
  logic        aIrq, bIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  shared_mailbox u_shared_mailbox (
    .clk(clk), .rst(rst), .countMode(countMode),
    .aAddr(aAddr), .aWrData(aWrData), .aWrEn(aWrEn), .aRdData(aRdData),
    .bAddr(bAddr), .bWrData(bWrData), .bWrEn(bWrEn), .bRdData(bRdData),
    .aIrq(aIrq), .bIrq(bIrq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int a, input logic [31:0] salt);
    return (32'(a) * 32'h0100_0193) ^ salt;
  endfunction

  function automatic logic [31:0] stat(input bit ovr, input bit flg,
                                       input logic [7:0] ack, input logic [7:0] cnt);
    return {14'b0, ovr, flg, ack, cnt};
  endfunction

  task automatic wrA(input logic [7:0] ad, input logic [31:0] d);
    aAddr = ad; aWrData = d; aWrEn = 1'b1;
    @(negedge clk);
    aWrEn = 1'b0;
  endtask

  task automatic wrB(input logic [7:0] ad, input logic [31:0] d);
    bAddr = ad; bWrData = d; bWrEn = 1'b1;
    @(negedge clk);
    bWrEn = 1'b0;
  endtask

  task automatic rdA(input logic [7:0] ad, output logic [31:0] d);
    aAddr = ad; aWrEn = 1'b0;
    @(negedge clk);
    d = aRdData;
  endtask

  task automatic rdB(input logic [7:0] ad, output logic [31:0] d);
    bAddr = ad; bWrEn = 1'b0;
    @(negedge clk);
    d = bRdData;
  endtask

  task automatic doReset(input bit mode);
    @(negedge clk);
    rst = 1'b1; countMode = mode; aWrEn = 1'b0; bWrEn = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  c;

    // ---- R10: reset state
    doReset(1'b0);
    chk("R10 aIrq", 32'(aIrq), 0);
    chk("R10 bIrq", 32'(bIrq), 0);
    chk("R10 aRdData", aRdData, 0);
    chk("R10 bRdData", bRdData, 0);
    rdB(8'hFE, v); chk("R10 status A-to-B", v, 0);
    rdA(8'hFF, v); chk("R10 status B-to-A", v, 0);

    // ---- R1: sweep A writes / B reads, then B writes / A reads
    for (int a = 0; a < 254; a++) wrA(8'(a), pat(a, 32'h5A00_0000));
    for (int a = 0; a < 254; a++) begin
      rdB(8'(a), v); chk("R1 A->B word", v, pat(a, 32'h5A00_0000));
    end
    for (int a = 0; a < 254; a++) wrB(8'(a), pat(a, 32'hC3C3_0F0F));
    for (int a = 0; a < 254; a++) begin
      rdA(8'(a), v); chk("R1 B->A word", v, pat(a, 32'hC3C3_0F0F));
    end

    // ---- R2: read-first on same address, both ports observing
    aAddr = 8'd30; aWrData = 32'hDEAD_BEEF; aWrEn = 1'b1; bAddr = 8'd30; bWrEn = 1'b0;
    @(negedge clk);
    aWrEn = 1'b0;
    chk("R2 A sees old", aRdData, pat(30, 32'hC3C3_0F0F));
    chk("R2 B sees old", bRdData, pat(30, 32'hC3C3_0F0F));
    rdB(8'd30, v); chk("R2 new after", v, 32'hDEAD_BEEF);

    // ---- R3: same-address write clash, then distinct addresses
    aAddr = 8'd40; aWrData = 32'hAAAA_0001; aWrEn = 1'b1;
    bAddr = 8'd40; bWrData = 32'hBBBB_0002; bWrEn = 1'b1;
    @(negedge clk);
    aWrEn = 1'b0; bWrEn = 1'b0;
    rdA(8'd40, v); chk("R3 A wins", v, 32'hAAAA_0001);
    aAddr = 8'd41; aWrData = 32'h1111_0041; aWrEn = 1'b1;
    bAddr = 8'd42; bWrData = 32'h2222_0042; bWrEn = 1'b1;
    @(negedge clk);
    aWrEn = 1'b0; bWrEn = 1'b0;
    rdB(8'd41, v); chk("R3 A distinct", v, 32'h1111_0041);
    rdA(8'd42, v); chk("R3 B distinct", v, 32'h2222_0042);

    // ---- counter mode
    doReset(1'b1);
    // R11: irq not high before the announcing edge, high after it
    aAddr = 8'hFE; aWrData = 32'h0; aWrEn = 1'b1;
    #1 chk("R11 bIrq before edge", 32'(bIrq), 0);
    @(negedge clk);
    aWrEn = 1'b0;
    chk("R11 bIrq after edge", 32'(bIrq), 1);
    for (int i = 2; i <= 260; i++) begin
      wrA(8'hFE, 32'(i));
      c = 8'(i);
      chk("R5 irq vs count", 32'(bIrq), (c != 8'd0) ? 32'd1 : 32'd0);
      chk("R9 aIrq quiet", 32'(aIrq), 0);
      rdB(8'hFE, v); chk("R4 R5 status count", v, stat(1'b0, 1'b0, 8'd0, c));
    end
    wrB(8'hFE, 32'hFFFF_FF04);
    chk("R5 ack clears irq", 32'(bIrq), 0);
    rdA(8'hFE, v); chk("R5 ack field", v, stat(1'b0, 1'b0, 8'd4, 8'd4));
    wrB(8'hFF, 32'h0);
    chk("R9 aIrq on B announce", 32'(aIrq), 1);
    chk("R9 bIrq unaffected", 32'(bIrq), 0);
    wrA(8'hFF, 32'h1);
    chk("R5 A ack", 32'(aIrq), 0);

    // ---- semaphore mode
    doReset(1'b0);
    wrA(8'hFE, 32'h1234);
    chk("R6 flag irq", 32'(bIrq), 1);
    chk("R9 aIrq quiet sem", 32'(aIrq), 0);
    rdB(8'hFE, v); chk("R4 R6 status flag", v, stat(1'b0, 1'b1, 8'd0, 8'd0));
    wrB(8'hFE, 32'h0);
    chk("R6 bit0 zero keeps flag", 32'(bIrq), 1);
    wrA(8'hFE, 32'h0);
    rdA(8'hFE, v); chk("R7 overrun set", v, stat(1'b1, 1'b1, 8'd0, 8'd0));
    wrB(8'hFE, 32'h1);
    chk("R6 clear irq", 32'(bIrq), 0);
    rdB(8'hFE, v); chk("R7 overrun sticky", v, stat(1'b1, 1'b0, 8'd0, 8'd0));
    wrB(8'hFE, 32'h2);
    rdB(8'hFE, v); chk("R7 overrun cleared", v, stat(1'b0, 1'b0, 8'd0, 8'd0));
    // R8: flag set, then clear and announce in one cycle
    wrA(8'hFE, 32'h0);
    aAddr = 8'hFE; aWrData = 32'h0; aWrEn = 1'b1;
    bAddr = 8'hFE; bWrData = 32'h1; bWrEn = 1'b1;
    @(negedge clk);
    aWrEn = 1'b0; bWrEn = 1'b0;
    rdB(8'hFE, v); chk("R8 set wins no overrun", v, stat(1'b0, 1'b1, 8'd0, 8'd0));
    // R9: B-to-A in semaphore mode
    wrB(8'hFF, 32'h0);
    chk("R9 aIrq sem", 32'(aIrq), 1);
    wrA(8'hFF, 32'h1);
    chk("R9 aIrq cleared", 32'(aIrq), 0);
    chk("R9 bIrq held", 32'(bIrq), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule